// File: doc/BRIEF.md
# Outstanding Request Limiter

This block stands between a request source and a responder that run on one clock. When the source asks for service, the block issues a single-cycle valid pulse to the responder. The responder later answers each pulse with a single-cycle acknowledge. The block keeps a count of the pulses that have not yet been answered. While that count sits at the ceiling, no new pulse leaves the block. Issue resumes on its own once an acknowledge brings the count back under the ceiling.

The block also keeps issued pulses apart: it never sends two valid pulses within any three consecutive cycles. It checks that acknowledges arrive with the same spacing. An acknowledge that comes too soon after the previous one is flagged as a protocol error and is not counted. So is an acknowledge that arrives while nothing is outstanding. The error flag stays set until reset.

A request that cannot be issued at once is remembered. It goes out as soon as both the spacing rule and the ceiling allow it.

Top module: `outstanding_limiter`

## Requirements
- R1: While reset (`rst_n` low) is applied and right after it, `valid_o`, `stall_o` and `proto_err_o` are 0 and `count_o` is 0.
- R2: With nothing outstanding and no spacing restriction, a request on `want_i` in cycle t gives a one-cycle `valid_o` pulse in cycle t+1.
- R3: Between any two `valid_o` pulses there are at least two cycles with `valid_o` low. This means at most one pulse in any 3 consecutive cycles.
- R4: A request that is blocked by spacing or by the ceiling is held inside the block. It is issued in the first cycle both restrictions have cleared, even if `want_i` has since dropped.
- R5: `count_o` rises by 1 the cycle after a `valid_o` pulse with no accepted acknowledge. It falls by 1 the cycle after an accepted acknowledge with no `valid_o` pulse. It is unchanged when both occur in the same cycle.
- R6: `stall_o` is 1 exactly when `count_o` equals 32. No `valid_o` pulse follows a cycle in which `stall_o` is 1. `count_o` never exceeds 32.
- R7: When an acknowledge brings the count from 32 to 31, a held request is issued one cycle after `stall_o` falls.
- R8: An acknowledge that arrives while `count_o` is 0 sets `proto_err_o` and leaves `count_o` unchanged.
- R9: An acknowledge in cycle t that follows another acknowledge in cycle t-1 or t-2 sets `proto_err_o` and is not counted.
- R10: `proto_err_o`, once set, stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| want_i | input | 1 | Source asks for one request to be issued |
| ack_i | input | 1 | Single-cycle acknowledge pulse from the responder |
| valid_o | output | 1 | Registered single-cycle request pulse to the responder |
| stall_o | output | 1 | High while the outstanding count is at the ceiling |
| count_o | output | 6 | Number of issued requests still awaiting an acknowledge |
| proto_err_o | output | 1 | Sticky flag for a misplaced acknowledge |

## Verification
A vector table drives isolated requests, requests that arrive during the spacing window, and an acknowledge in the same cycle as a valid pulse. Together these separate a registered issue from a held issue and show a net-zero count step. A held request shows that the block remembers it: the pulse comes out after `want_i` has dropped. A continuous request stream fills the count to the ceiling and keeps testing the spacing rule all the way. A single acknowledge at the ceiling then shows stall release and the issue that follows. Acknowledges with nothing outstanding, and two acknowledges in back-to-back cycles, separate the two error causes from the accepted case, and later cycles show the flag stays set.

// File: rtl/lim_pkg.sv
`timescale 1ns/1ps
// lim_pkg: types shared by the outstanding limiter modules.
package lim_pkg;
    // Decision taken on one acknowledge pulse.
    typedef struct packed {
        logic take;   // acknowledge is counted
        logic bad;    // acknowledge violates the protocol
    } ack_verdict_t;
endpackage

// File: rtl/lim_issue_gate.sv
`timescale 1ns/1ps
// lim_issue_gate
// Turns a request level or pulse into spaced, registered valid pulses.
// A request that cannot go out yet is kept in pend_q until the stall input
// is low and the spacing counter has run down.
// Assumes: SPACING >= 2, so that the count reflects the previous pulse
// before the next issue decision is taken.
module lim_issue_gate #(
    parameter int SPACING = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic stall_i,
    output logic valid_o
);
    localparam int GW = (SPACING > 2) ? $clog2(SPACING) : 1;

    logic [GW-1:0] gap_q;
    logic          pend_q;
    logic          valid_q;
    logic          fire;

    // Issue when a request is present, the ceiling is not reached and spacing is clear.
    always_comb begin
        fire = (want_i | pend_q) & ~stall_i & (gap_q == '0);
    end

    // Register the pulse, keep unserved requests, and reload or run down the spacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            valid_q <= fire;
            pend_q  <= (pend_q | want_i) & ~fire;
            if (fire) begin
                gap_q <= GW'(SPACING - 1);
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
endmodule

// File: rtl/lim_ack_monitor.sv
`timescale 1ns/1ps
// lim_ack_monitor
// Judges each acknowledge pulse. An acknowledge is rejected when nothing is
// outstanding, or when it comes less than ACK_SPACING cycles after the
// previous acknowledge. Every acknowledge restarts the spacing window,
// accepted or not. Rejections set a sticky error flag.
// Assumes: ack_i is synchronous to clk.
module lim_ack_monitor
    import lim_pkg::*;
#(
    parameter int ACK_SPACING = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_i,
    input  logic         empty_i,
    output ack_verdict_t verdict_o,
    output logic         err_o
);
    localparam int GW = (ACK_SPACING > 2) ? $clog2(ACK_SPACING) : 1;

    logic [GW-1:0] gap_q;
    logic          err_q;
    ack_verdict_t  verdict;

    // Classify the current acknowledge.
    always_comb begin
        verdict.bad  = ack_i & (empty_i | (gap_q != '0));
        verdict.take = ack_i & ~verdict.bad;
    end

    // Track the spacing since the last acknowledge and hold any error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= err_q | verdict.bad;
            if (ack_i) begin
                gap_q <= GW'(ACK_SPACING - 1);
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign verdict_o = verdict;
    assign err_o     = err_q;
endmodule

// File: rtl/lim_credit_counter.sv
`timescale 1ns/1ps
// lim_credit_counter
// Up/down count of outstanding requests, bounded to 0..CEILING.
// Assumes: the caller never raises up_i at the ceiling or down_i at zero.
// The guards only keep the range safe if that assumption is broken.
module lim_credit_counter #(
    parameter int CEILING = 32,
    localparam int CW = $clog2(CEILING + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_i,
    input  logic          down_i,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    logic [CW-1:0] cnt_q;

    // Apply the net change of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({up_i, down_i})
                2'b10:   if (cnt_q != CW'(CEILING)) cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o = cnt_q;
    assign full_o  = (cnt_q == CW'(CEILING));
    assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/outstanding_limiter.sv
`timescale 1ns/1ps
// outstanding_limiter
// Issues spaced request pulses and keeps at most CEILING of them unanswered.
// Acknowledges that are too close together, or that come while nothing is
// outstanding, are flagged and not counted.
// Assumes: one clock domain; REQ_SPACING >= 2.
module outstanding_limiter
    import lim_pkg::*;
#(
    parameter int CEILING     = 32,
    parameter int REQ_SPACING = 3,
    parameter int ACK_SPACING = 3,
    localparam int CW = $clog2(CEILING + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          want_i,
    input  logic          ack_i,
    output logic          valid_o,
    output logic          stall_o,
    output logic [CW-1:0] count_o,
    output logic          proto_err_o
);
    logic         valid;
    logic         full;
    logic         empty;
    ack_verdict_t verdict;

    lim_issue_gate #(.SPACING(REQ_SPACING)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_i  (want_i),
        .stall_i (full),
        .valid_o (valid)
    );

    lim_ack_monitor #(.ACK_SPACING(ACK_SPACING)) u_ackmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_i     (ack_i),
        .empty_i   (empty),
        .verdict_o (verdict),
        .err_o     (proto_err_o)
    );

    lim_credit_counter #(.CEILING(CEILING)) u_credit (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_i    (valid),
        .down_i  (verdict.take),
        .count_o (count_o),
        .full_o  (full),
        .empty_o (empty)
    );

    assign valid_o = valid;
    assign stall_o = full;
endmodule

// File: rtl/lim_checker.sv
`timescale 1ns/1ps
// lim_checker
// Protocol properties of outstanding_limiter, observed at its ports.
module lim_checker #(
    parameter int CEILING = 32,
    localparam int CW = $clog2(CEILING + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_i,
    input logic          valid_o,
    input logic          stall_o,
    input logic [CW-1:0] count_o,
    input logic          proto_err_o
);
    // R3: a pulse is followed by two quiet cycles.
    a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o ##1 !valid_o);

    // R6: no pulse right after a stalled cycle.
    a_r6_no_issue_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !valid_o);

    // R5: a pulse without an acknowledge raises the count by one.
    a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i) |=> (count_o == $past(count_o) + 1'b1));

    // R8: an acknowledge at zero flags an error and is not counted.
    a_r8_ack_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !valid_o && count_o == '0) |=> (proto_err_o && count_o == '0));

    // R10: the error flag holds.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);

    // R6: the count stays in range.
    always @(posedge clk) begin
        if (rst_n) begin
            a_r6_bound: assert (count_o <= CW'(CEILING));
        end
    end
endmodule

bind outstanding_limiter lim_checker #(.CEILING(CEILING)) u_lim_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .valid_o     (valid_o),
    .stall_o     (stall_o),
    .count_o     (count_o),
    .proto_err_o (proto_err_o)
);

// File: tb/outstanding_limiter_test.sv
`timescale 1ns/1ps
module outstanding_limiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       want_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       valid_o;
    logic       stall_o;
    logic [5:0] count_o;
    logic       proto_err_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    outstanding_limiter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_i      (want_i),
        .ack_i       (ack_i),
        .valid_o     (valid_o),
        .stall_o     (stall_o),
        .count_o     (count_o),
        .proto_err_o (proto_err_o)
    );

    always #10 clk = ~clk;

    // Row layout: {want, ack, expected valid, expected count[5:0]}; checked
    // on the falling edge after the rising edge that consumes the row.
    localparam logic [8:0] VEC [0:12] = '{
        9'b1_0_1_000000,  // R2 isolated request issued next cycle
        9'b0_0_0_000001,  // R5 count follows the pulse
        9'b1_0_0_000001,  // R4 request inside spacing window is held
        9'b0_0_1_000001,  // R4 held request issued after want dropped
        9'b0_1_0_000001,  // R5 pulse and acknowledge together: no change
        9'b0_0_0_000001,
        9'b0_0_0_000001,
        9'b0_1_0_000000,  // R9 acknowledge three cycles later is accepted
        9'b1_0_1_000000,  // R2
        9'b1_0_0_000001,  // R3 back-to-back want does not give a pulse
        9'b0_0_0_000001,
        9'b0_0_1_000001,  // R3 next pulse after two quiet cycles
        9'b0_0_0_000010
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        want_i = 1'b0;
        ack_i  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int pulses;
        int last;
        // R1 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", int'(valid_o), 0);
        check("R1 count", int'(count_o), 0);
        check("R1 stall", int'(stall_o), 0);
        check("R1 err", int'(proto_err_o), 0);
        rst_n = 1'b1;

        // Vector table
        foreach (VEC[i]) begin
            want_i = VEC[i][8];
            ack_i  = VEC[i][7];
            @(negedge clk);
            check($sformatf("R2/R4/R5 row%0d valid", i), int'(valid_o), int'(VEC[i][6]));
            check($sformatf("R5 row%0d count", i), int'(count_o), int'(VEC[i][5:0]));
        end
        want_i = 1'b0;
        ack_i  = 1'b0;
        check("R9 no error in table", int'(proto_err_o), 0);

        // Fill to the ceiling with a continuous request
        do_reset();
        want_i = 1'b1;
        pulses = 0;
        last = -10;
        for (int c = 0; c < 140; c++) begin
            @(negedge clk);
            if (valid_o) begin
                if (c - last < 3) check("R3 spacing in stream", c - last, 3);
                pulses++;
                last = c;
            end
        end
        check("R6 pulses to ceiling", pulses, 32);
        check("R6 count at ceiling", int'(count_o), 32);
        check("R6 stall at ceiling", int'(stall_o), 1);
        pulses = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (valid_o) pulses++;
        end
        check("R6 no pulse while stalled", pulses, 0);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        check("R7 count after ack", int'(count_o), 31);
        check("R7 stall released", int'(stall_o), 0);
        check("R7 no pulse yet", int'(valid_o), 0);
        @(negedge clk);
        check("R7 resumed pulse", int'(valid_o), 1);
        @(negedge clk);
        check("R6 count back at ceiling", int'(count_o), 32);
        check("R6 stall again", int'(stall_o), 1);
        want_i = 1'b0;

        // Acknowledge with nothing outstanding
        do_reset();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        check("R8 error on empty ack", int'(proto_err_o), 1);
        check("R8 count unchanged", int'(count_o), 0);

        // Acknowledges too close together
        do_reset();
        want_i = 1'b1;
        repeat (4) @(negedge clk);
        want_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 two outstanding", int'(count_o), 2);
        ack_i = 1'b1;
        @(negedge clk);
        check("R9 first ack accepted", int'(count_o), 1);
        check("R9 no error yet", int'(proto_err_o), 0);
        @(negedge clk);
        ack_i = 1'b0;
        check("R9 close ack flagged", int'(proto_err_o), 1);
        check("R9 close ack not counted", int'(count_o), 1);
        repeat (5) @(negedge clk);
        check("R10 error held", int'(proto_err_o), 1);
        check("R10 count after error", int'(count_o), 1);

        report();
    end
endmodule